// File: doc/BRIEF.md
# Shaft-Angle Step Sequencer

This block drives a set of output lines from the angle of a shaft that turns at constant speed. An incremental encoder on the shaft gives a count clock with a fixed number of edges per turn, plus one index pulse per turn. The block counts the encoder edges and compares the running count with the preset of the active step in an eight-entry table. Each table entry holds a preset and an output pattern. When the count reaches the active preset, the block moves to the next entry and drives that entry's pattern. The outputs therefore change at fixed shaft angles, not at fixed times.

Each index pulse clears the count and returns the block to entry 0. A programmable last-step number sets how many entries a turn uses. After the match on the last used entry, the outputs hold until the next index pulse.

Three sticky event flags report events to a host: a compare match, an index rewind and a counter wrap. Each flag has its own enable and is cleared by writing 1. The host loads the table while the block is disabled.

Top module: `shaft_step_seq`

## Requirements
- R1: After reset, `count_o`, `step_o`, `out_o`, `flags_o` and `irq_o` are all zero.
- R2: While `run_i` is high, each rising edge of `enc_clk_i` adds one to `count_o`. While `run_i` is low, `count_o` and `step_o` stay at zero and `out_o` is zero.
- R3: If the count after an increment equals the preset of the active step, and that step is not the last used one, `step_o` advances by one and `out_o` takes the pattern of the new step.
- R4: A match on step `last_step_i` latches a done state. After that, `step_o` and `out_o` hold and no further match events occur, while `count_o` keeps counting, until the next index pulse.
- R5: A rising edge of `enc_idx_i` while running clears `count_o`, sets `step_o` to 0, leaves the done state and drives the pattern of entry 0. The same entry-0 pattern appears when `run_i` first goes high.
- R6: When the index edge and an encoder clock edge are detected in the same system clock cycle, the index takes priority and `count_o` becomes 0.
- R7: `flags_o` bit 0 is the match event, bit 1 the index event and bit 2 the counter wrap.
  - A flag sets only when its bit in `evt_en_i` is 1.
  - A set flag stays set until the host writes 1 to the same bit of `evt_clr_i`.
  - Clearing one flag leaves the others unchanged.
- R8: An increment from the all-ones count wraps `count_o` to 0 and raises the wrap event.
- R9: A table write made while `run_i` is high has no effect on the stored entry.
- R10: `irq_o` is high exactly when at least one bit of `flags_o` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enc_clk_i | input | 1 | Encoder count clock, asynchronous |
| enc_idx_i | input | 1 | Encoder once-per-turn index, asynchronous |
| run_i | input | 1 | Enable; low keeps the block idle and allows table writes |
| last_step_i | input | AW | Number of the last table entry used in a turn |
| tbl_we_i | input | 1 | Table write strobe |
| tbl_addr_i | input | AW | Table entry to write |
| tbl_preset_i | input | CNT_W | Preset value to write |
| tbl_pattern_i | input | PAT_W | Output pattern to write |
| evt_en_i | input | 3 | Per-flag enables (bit 0 match, bit 1 index, bit 2 wrap) |
| evt_clr_i | input | 3 | Write-1-to-clear strobes for the flags |
| count_o | output | CNT_W | Current encoder count |
| step_o | output | AW | Active table entry |
| out_o | output | PAT_W | Driven output pattern |
| flags_o | output | 3 | Sticky event flags |
| irq_o | output | 1 | OR of the event flags |

## Verification
The hardest condition to reach from the ports is the counter wrap. At full width it needs tens of thousands of encoder edges, each of which must pass through the synchronizers. The bench therefore builds the block with a 10-bit counter and walks the count through two full wraps, the first with the wrap flag disabled and the second with it enabled. The index-versus-clock collision is reached by raising both asynchronous inputs in the same bench step, so that both synchronizers detect them in the same cycle. Step sequencing is swept for every last-step setting, and each encoder edge is compared against an arithmetic model.

// File: rtl/shaft_seq_pkg.sv
package shaft_seq_pkg;
  localparam int EVT_N = 3;

  // bit 0 match, bit 1 index, bit 2 wrap
  typedef struct packed {
    logic wrap;
    logic index;
    logic match;
  } evt_t;
endpackage

// File: rtl/enc_edge_sync.sv
module enc_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], async_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;

  // R2: a detected edge lasts one system cycle
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (rst)
    rise_o |=> !rise_o);
endmodule

// File: rtl/preset_table.sv
module preset_table #(
  parameter int DEPTH = 8,
  parameter int CNT_W = 16,
  parameter int PAT_W = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [CNT_W-1:0] wpreset,
  input  logic [PAT_W-1:0] wpattern,
  input  logic [AW-1:0]    preset_addr,
  output logic [CNT_W-1:0] preset_rd,
  input  logic [AW-1:0]    pattern_addr,
  output logic [PAT_W-1:0] pattern_rd
);
  logic [CNT_W-1:0] preset_mem  [DEPTH];
  logic [PAT_W-1:0] pattern_mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      preset_mem[waddr]  <= wpreset;
      pattern_mem[waddr] <= wpattern;
    end
  end

  assign preset_rd  = preset_mem[preset_addr];
  assign pattern_rd = pattern_mem[pattern_addr];
endmodule

// File: rtl/step_engine.sv
module step_engine
  import shaft_seq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int CNT_W = 16,
  parameter int PAT_W = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             cnt_p,
  input  logic             idx_p,
  input  logic [AW-1:0]    last_step,
  input  logic [CNT_W-1:0] preset_rd,
  input  logic [PAT_W-1:0] pattern_rd,
  output logic [AW-1:0]    step_nxt,
  output logic [CNT_W-1:0] count_q,
  output logic [AW-1:0]    step_q,
  output logic [PAT_W-1:0] out_q,
  output evt_t             evt
);
  logic             done_q, done_n;
  logic [CNT_W-1:0] count_n, cnt_inc;

  assign cnt_inc = count_q + CNT_W'(1);

  always_comb begin
    count_n  = count_q;
    step_nxt = step_q;
    done_n   = done_q;
    evt      = '0;
    if (!run) begin
      count_n  = '0;
      step_nxt = '0;
      done_n   = 1'b0;
    end else if (idx_p) begin
      count_n   = '0;
      step_nxt  = '0;
      done_n    = 1'b0;
      evt.index = 1'b1;
    end else if (cnt_p) begin
      count_n  = cnt_inc;
      evt.wrap = &count_q;
      if (!done_q && cnt_inc == preset_rd) begin
        evt.match = 1'b1;
        if (step_q == last_step) done_n = 1'b1;
        else step_nxt = AW'(step_q + 1'b1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
      step_q  <= '0;
      done_q  <= 1'b0;
      out_q   <= '0;
    end else begin
      count_q <= count_n;
      step_q  <= step_nxt;
      done_q  <= done_n;
      out_q   <= run ? pattern_rd : '0;
    end
  end

  // R2: counting by one per detected edge
  a_r2_count_step: assert property (@(posedge clk) disable iff (rst)
    run && cnt_p && !idx_p |=> count_q == CNT_W'($past(count_q) + 1'b1));

  // R2: idle while disabled
  a_r2_idle_off: assert property (@(posedge clk) disable iff (rst)
    !run |=> count_q == '0 && step_q == '0 && out_q == '0);

  // R4: held after the last match
  a_r4_hold_done: assert property (@(posedge clk) disable iff (rst)
    run && done_q && !idx_p |=> !run || ($stable(step_q) && $stable(out_q)));

  // R5: index rewinds the sequence
  a_r5_index_rewind: assert property (@(posedge clk) disable iff (rst)
    run && idx_p |=> count_q == '0 && step_q == '0 && !done_q);

  // R6: index beats a simultaneous count edge
  a_r6_index_wins: assert property (@(posedge clk) disable iff (rst)
    run && idx_p && cnt_p |=> count_q == '0);

  // R3: step never moves without a match or rewind
  a_r3_step_cause: assert property (@(posedge clk) disable iff (rst)
    run && !idx_p && !evt.match |=> !run || $stable(step_q));
endmodule

// File: rtl/event_flags.sv
module event_flags
  import shaft_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  evt_t             evt,
  input  logic [EVT_N-1:0] en,
  input  logic [EVT_N-1:0] clr,
  output logic [EVT_N-1:0] flags_q,
  output logic             irq_q
);
  logic [EVT_N-1:0] set_v, flags_n;

  assign set_v   = evt & en;
  assign flags_n = (flags_q & ~clr) | set_v;

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      flags_q <= flags_n;
      irq_q   <= |flags_n;
    end
  end

  for (genvar i = 0; i < EVT_N; i++) begin : g_flag
    // R7: sticky until cleared
    a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
      flags_q[i] && !clr[i] |=> flags_q[i]);
    // R7: write-1 clears when no new event
    a_r7_clear: assert property (@(posedge clk) disable iff (rst)
      clr[i] && !(evt[i] && en[i]) |=> !flags_q[i]);
    // R7: disabled events never set
    a_r7_gated: assert property (@(posedge clk) disable iff (rst)
      !flags_q[i] && !en[i] |=> !flags_q[i]);
  end

  // R10: interrupt follows the flags
  a_r10_irq: assert property (@(posedge clk) disable iff (rst)
    irq_q == (flags_q != '0));
endmodule

// File: rtl/shaft_step_seq.sv
module shaft_step_seq
  import shaft_seq_pkg::*;
#(
  parameter int DEPTH       = 8,
  parameter int CNT_W       = 16,
  parameter int PAT_W       = 8,
  parameter int SYNC_STAGES = 2,
  localparam int AW         = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enc_clk_i,
  input  logic             enc_idx_i,
  input  logic             run_i,
  input  logic [AW-1:0]    last_step_i,
  input  logic             tbl_we_i,
  input  logic [AW-1:0]    tbl_addr_i,
  input  logic [CNT_W-1:0] tbl_preset_i,
  input  logic [PAT_W-1:0] tbl_pattern_i,
  input  logic [EVT_N-1:0] evt_en_i,
  input  logic [EVT_N-1:0] evt_clr_i,
  output logic [CNT_W-1:0] count_o,
  output logic [AW-1:0]    step_o,
  output logic [PAT_W-1:0] out_o,
  output logic [EVT_N-1:0] flags_o,
  output logic             irq_o
);
  logic             cnt_p, idx_p;
  logic [AW-1:0]    step_nxt;
  logic [CNT_W-1:0] preset_rd;
  logic [PAT_W-1:0] pattern_rd;
  evt_t             evt;

  enc_edge_sync #(.STAGES(SYNC_STAGES)) u_clk_sync (
    .clk(clk), .rst(rst), .async_i(enc_clk_i), .rise_o(cnt_p));

  enc_edge_sync #(.STAGES(SYNC_STAGES)) u_idx_sync (
    .clk(clk), .rst(rst), .async_i(enc_idx_i), .rise_o(idx_p));

  preset_table #(.DEPTH(DEPTH), .CNT_W(CNT_W), .PAT_W(PAT_W)) u_table (
    .clk(clk), .we(tbl_we_i && !run_i), .waddr(tbl_addr_i),
    .wpreset(tbl_preset_i), .wpattern(tbl_pattern_i),
    .preset_addr(step_o), .preset_rd(preset_rd),
    .pattern_addr(step_nxt), .pattern_rd(pattern_rd));

  step_engine #(.DEPTH(DEPTH), .CNT_W(CNT_W), .PAT_W(PAT_W)) u_engine (
    .clk(clk), .rst(rst), .run(run_i), .cnt_p(cnt_p), .idx_p(idx_p),
    .last_step(last_step_i), .preset_rd(preset_rd), .pattern_rd(pattern_rd),
    .step_nxt(step_nxt), .count_q(count_o), .step_q(step_o), .out_q(out_o),
    .evt(evt));

  event_flags u_flags (
    .clk(clk), .rst(rst), .evt(evt), .en(evt_en_i), .clr(evt_clr_i),
    .flags_q(flags_o), .irq_q(irq_o));
endmodule

// File: tb/tb_shaft_step_seq.sv
module tb_shaft_step_seq;
  localparam int CLK_P = 10;
  localparam int DEPTH = 8;
  localparam int CNT_W = 10;
  localparam int PAT_W = 8;
  localparam int AW    = 3;

  logic clk = 0, rst = 1;
  logic enc_clk = 0, enc_idx = 0, run = 0;
  logic [AW-1:0] last_step = '0;
  logic tbl_we = 0;
  logic [AW-1:0] tbl_addr = '0;
  logic [CNT_W-1:0] tbl_preset = '0;
  logic [PAT_W-1:0] tbl_pattern = '0;
  logic [2:0] evt_en = '0, evt_clr = '0;
  logic [CNT_W-1:0] count;
  logic [AW-1:0] step;
  logic [PAT_W-1:0] outp;
  logic [2:0] flags;
  logic irq;

  int checks = 0, errors = 0;
  bit done_run = 0;

  int m_cnt, m_step;
  bit m_done;

  shaft_step_seq #(.DEPTH(DEPTH), .CNT_W(CNT_W), .PAT_W(PAT_W)) dut (
    .clk(clk), .rst(rst), .enc_clk_i(enc_clk), .enc_idx_i(enc_idx),
    .run_i(run), .last_step_i(last_step), .tbl_we_i(tbl_we),
    .tbl_addr_i(tbl_addr), .tbl_preset_i(tbl_preset),
    .tbl_pattern_i(tbl_pattern), .evt_en_i(evt_en), .evt_clr_i(evt_clr),
    .count_o(count), .step_o(step), .out_o(outp), .flags_o(flags),
    .irq_o(irq));

  always #(CLK_P/2) clk = ~clk;

  function automatic int pre(int i);
    return (i + 1) * 5 - 2;
  endfunction

  function automatic int pat(int i);
    return (8'h3C ^ (i * 37)) & 8'hFF;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic enc_edge();
    @(negedge clk); enc_clk = 1; cyc(2);
    enc_clk = 0; cyc(2);
  endtask

  task automatic index_pulse();
    @(negedge clk); enc_idx = 1; cyc(2);
    enc_idx = 0; cyc(2);
    m_cnt = 0; m_step = 0; m_done = 0;
  endtask

  task automatic write_entry(int a, int p, int q);
    @(negedge clk);
    tbl_we = 1; tbl_addr = AW'(a); tbl_preset = CNT_W'(p); tbl_pattern = PAT_W'(q);
    @(negedge clk); tbl_we = 0;
  endtask

  task automatic model_edge();
    int nxt;
    nxt = (m_cnt + 1) % (1 << CNT_W);
    if (!m_done && nxt == pre(m_step)) begin
      if (m_step == int'(last_step)) m_done = 1;
      else m_step++;
    end
    m_cnt = nxt;
  endtask

  task automatic pulse_clr(logic [2:0] v);
    @(negedge clk); evt_clr = v; @(negedge clk); evt_clr = '0; cyc(2);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done_run) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    cyc(4); rst = 0; cyc(2);
    // R1 reset state
    check("R1 count", count, 0);
    check("R1 step", step, 0);
    check("R1 out", outp, 0);
    check("R1 flags", flags, 0);
    check("R1 irq", irq, 0);

    for (int i = 0; i < DEPTH; i++) write_entry(i, pre(i), pat(i));

    // R2 disabled: edges ignored
    repeat (5) enc_edge();
    cyc(3);
    check("R2 idle count", count, 0);
    check("R2 idle out", outp, 0);

    evt_en = 3'b011;
    // Sweep every last-step setting
    for (int ls = 0; ls < DEPTH; ls++) begin
      @(negedge clk); run = 0; last_step = AW'(ls); cyc(2);
      run = 1; cyc(3);
      m_cnt = 0; m_step = 0; m_done = 0;
      check("R5 start pattern", outp, pat(0));
      for (int e = 0; e < 45; e++) begin
        enc_edge(); model_edge(); cyc(2);
        check("R2 count", count, m_cnt);
        check(m_done ? "R4 step" : "R3 step", step, m_step);
        check(m_done ? "R4 out" : "R3 out", outp, pat(m_step));
      end
      index_pulse(); cyc(2);
      check("R5 index count", count, 0);
      check("R5 index step", step, 0);
      check("R5 index out", outp, pat(0));
    end

    // R7 flags set, w1c per bit
    check("R7 match flag", flags[0], 1);
    check("R7 index flag", flags[1], 1);
    check("R7 wrap flag gated", flags[2], 0);
    check("R10 irq set", irq, 1);
    pulse_clr(3'b001);
    check("R7 match cleared", flags[0], 0);
    check("R7 index kept", flags[1], 1);
    pulse_clr(3'b010);
    check("R7 index cleared", flags[1], 0);
    check("R10 irq clear", irq, 0);

    // R6 simultaneous index and clock
    repeat (2) enc_edge();
    @(negedge clk); enc_clk = 1; enc_idx = 1; cyc(2);
    enc_clk = 0; enc_idx = 0; cyc(3);
    check("R6 count", count, 0);
    check("R6 step", step, 0);

    // R9 write while running ignored
    write_entry(1, pre(1), 8'hFF);
    index_pulse();
    repeat (pre(0)) enc_edge();
    cyc(2);
    check("R9 step", step, 1);
    check("R9 pattern kept", outp, pat(1));

    // R8 wrap, first with flag disabled
    pulse_clr(3'b111);
    evt_en = 3'b000;
    @(negedge clk); run = 0; last_step = '0; cyc(2); run = 1; cyc(2);
    for (int k = 0; k < (1 << CNT_W); k++) enc_edge();
    cyc(2);
    check("R8 wrap count", count, 0);
    check("R7 wrap gated off", flags[2], 0);
    evt_en = 3'b100;
    for (int k = 0; k < (1 << CNT_W) - 1; k++) enc_edge();
    cyc(2);
    check("R8 full count", count, (1 << CNT_W) - 1);
    check("R8 no wrap yet", flags[2], 0);
    enc_edge(); cyc(2);
    check("R8 wrapped", count, 0);
    check("R8 wrap flag", flags[2], 1);
    check("R10 irq wrap", irq, 1);
    check("R4 held step", step, 0);

    done_run = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule